// File: doc/BRIEF.md
# Shared-Memory Setup Message Sequencer

This block sits behind the byte stream coming from a shared-memory control server. Bytes arrive one per cycle when `rx_valid` is high, in chunks of any size with idle cycles anywhere in between. A sideband flag, `rx_handle`, tells whether an event handle travels with the current message. Eight bytes form one signed 64-bit message, least significant byte first. A message is acted upon in the cycle its eighth byte is taken.

The block enforces a fixed startup order. The protocol version comes first, then the block's own peer number. After that come peer connect and disconnect messages, in any number, until the shared-memory announcement (value -1) finishes setup. In the run phase the block keeps handling connects and disconnects. For each peer it counts the vectors registered so far, and that count is the vector number handed out with the next connect. It reports connect, disconnect and memory-ready events as single-cycle strobes. Protocol violations raise a sticky error flag, and the code of the first error is kept.

Top module: `setup_msg_sequencer`

## Requirements
- R1: A message is the 8 bytes taken on `rx_valid` cycles, and the first byte taken is bits 7:0. Idle cycles between bytes are allowed. Event and error outputs change only in the cycle after the clock edge that takes the eighth byte.
- R2: The first message must equal `PROTO_VERSION` and carry no handle. Otherwise error code 1 is raised.
- R3: The second message must carry no handle and lie in 0..65535, and it becomes the own ID. Otherwise error code 2 is raised.
- R4: When `cfg_master` is high and the own ID is not 0, error code 7 is raised.
- R5: After the ID phase, a value below -1 or above 65535 raises error code 3 and produces no event.
- R6: The value -1 during setup gives one `mem_ready` strobe and enters the run phase. A later -1 raises error code 4 and gives no strobe. At most one of `conn_stb`, `disc_stb` and `mem_ready` is high in any cycle.
- R7: A peer message with a handle gives `conn_stb` with that peer and with `conn_vec` equal to the number of earlier accepted connects of that peer since its last reset. The count then rises by one.
- R8: A connect to a peer whose count already equals `NUM_VECTORS` raises error code 5, gives no strobe and leaves the count unchanged.
- R9: A valid peer message without a handle gives `disc_stb` with that peer and resets its count to 0, so the next connect of that peer gets vector 0.
- R10: A disconnect is invalid, with error code 6 and no strobe, when the peer equals the own ID or is at or above the capacity held before the message.
- R11: Capacity starts at 16. Any peer message with peer number at or above the capacity raises the capacity to peer+1, including a message rejected by R8 or R10.
- R12: A peer number at or above `MAX_PEERS` (the count storage) raises error code 8 and produces no event.
- R13: `err_flag` is sticky, and `err_code` keeps the first error's code. An error before the run phase halts the block, which then ignores every further message until reset. In the run phase the block reports errors and keeps processing messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | Master configuration, own ID must be 0 |
| rx_valid | input | 1 | A byte is present this cycle |
| rx_byte | input | 8 | Stream byte |
| rx_handle | input | 1 | Handle accompanies the message, sampled with the eighth byte |
| conn_stb | output | 1 | Connect event strobe |
| conn_peer | output | 16 | Peer of the connect event |
| conn_vec | output | $clog2(NUM_VECTORS+1) | Vector index of the connect event |
| disc_stb | output | 1 | Disconnect event strobe |
| disc_peer | output | 16 | Peer of the disconnect event |
| mem_ready | output | 1 | Shared memory announced, setup complete |
| err_flag | output | 1 | Sticky protocol error |
| err_code | output | 4 | Code of the first error |

## Verification
The assertions check the following on every cycle:
- the three event strobes are mutually exclusive;
- connect vectors stay below the vector limit;
- no per-peer count passes that limit;
- capacity never shrinks;
- the error flag and its code hold once set;
- a halted block emits nothing;
- a disconnect never names the own ID.

The implicit vector numbering, the growth of capacity, the first-error priority and the split between halting and continuing after an error depend on whole message sequences. Only the bench's scenarios show these, with its reference model checked against the outputs on each clock.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    localparam int ID_LIMIT = 65535;

    typedef enum logic [2:0] {
        PH_VER, PH_ID, PH_SETUP, PH_RUN, PH_HALT
    } phase_e;

    typedef enum logic [3:0] {
        E_NONE     = 4'd0,
        E_VERSION  = 4'd1,
        E_ID       = 4'd2,
        E_RANGE    = 4'd3,
        E_DUP_MEM  = 4'd4,
        E_VEC_FULL = 4'd5,
        E_DISC     = 4'd6,
        E_MASTER   = 4'd7,
        E_NO_ROOM  = 4'd8
    } err_e;
endpackage

// File: rtl/ssq_byte_assembler.sv
module ssq_byte_assembler #(
    parameter int MSG_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic [7:0]             in_byte,
    input  logic                   in_hnd,
    output logic                   out_vld,
    output logic [MSG_BYTES*8-1:0] out_val,
    output logic                   out_hnd
);
    localparam int CW   = $clog2(MSG_BYTES);
    localparam int BUFW = (MSG_BYTES - 1) * 8;

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [BUFW-1:0] data;
    } asm_t;

    asm_t q, d;
    logic last;

    always_comb begin
        d    = q;
        last = in_vld && (q.cnt == CW'(MSG_BYTES - 1));
        if (in_vld) begin
            if (last) begin
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
                d.data[q.cnt*8 +: 8] = in_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_vld = last;
    assign out_val = {in_byte, q.data};
    assign out_hnd = in_hnd;
endmodule

// File: rtl/ssq_peer_counts.sv
module ssq_peer_counts #(
    parameter int NUM_PEERS   = 32,
    parameter int NUM_VECTORS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [$clog2(NUM_PEERS)-1:0]         idx,
    input  logic                                 inc,
    input  logic                                 clr,
    output logic [$clog2(NUM_VECTORS+1)-1:0]     cnt_o
);
    localparam int PW = $clog2(NUM_PEERS);
    localparam int CW = $clog2(NUM_VECTORS + 1);

    logic [CW-1:0] cnt_q [NUM_PEERS];
    logic [CW-1:0] cnt_d [NUM_PEERS];

    for (genvar g = 0; g < NUM_PEERS; g++) begin : g_entry
        always_comb begin
            cnt_d[g] = cnt_q[g];
            if (idx == PW'(g)) begin
                if (clr)      cnt_d[g] = '0;
                else if (inc) cnt_d[g] = cnt_q[g] + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q[g] <= '0;
            else        cnt_q[g] <= cnt_d[g];
        end

        // R8: the sequencer never lets a count pass the vector limit
        a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[g] <= CW'(NUM_VECTORS));
    end

    assign cnt_o = cnt_q[idx];
endmodule

// File: rtl/setup_msg_sequencer.sv
module setup_msg_sequencer
    import ssq_pkg::*;
#(
    parameter logic [63:0] PROTO_VERSION = 64'd0,
    parameter int          NUM_VECTORS   = 4,
    parameter int          MAX_PEERS     = 32,
    parameter int          INIT_CAP      = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_master,
    input  logic                              rx_valid,
    input  logic [7:0]                        rx_byte,
    input  logic                              rx_handle,
    output logic                              conn_stb,
    output logic [15:0]                       conn_peer,
    output logic [$clog2(NUM_VECTORS+1)-1:0]  conn_vec,
    output logic                              disc_stb,
    output logic [15:0]                       disc_peer,
    output logic                              mem_ready,
    output logic                              err_flag,
    output logic [3:0]                        err_code
);
    localparam int CW = $clog2(NUM_VECTORS + 1);
    localparam int PW = $clog2(MAX_PEERS);

    typedef struct packed {
        phase_e        phase;
        logic [16:0]   cap;
        logic [15:0]   own;
        logic          err;
        err_e          code;
        logic          conn;
        logic [15:0]   conn_peer;
        logic [CW-1:0] conn_vec;
        logic          disc;
        logic [15:0]   disc_peer;
        logic          mem;
    } seq_t;

    seq_t q, d;

    logic        msg_vld, msg_hnd;
    logic [63:0] msg_val;
    logic        cnt_inc, cnt_clr;
    logic [CW-1:0] cur_cnt;

    ssq_byte_assembler #(.MSG_BYTES(8)) i_asm (
        .clk(clk), .rst_n(rst_n),
        .in_vld(rx_valid), .in_byte(rx_byte), .in_hnd(rx_handle),
        .out_vld(msg_vld), .out_val(msg_val), .out_hnd(msg_hnd)
    );

    logic [15:0] peer;
    assign peer = msg_val[15:0];

    ssq_peer_counts #(.NUM_PEERS(MAX_PEERS), .NUM_VECTORS(NUM_VECTORS)) i_cnt (
        .clk(clk), .rst_n(rst_n),
        .idx(peer[PW-1:0]), .inc(cnt_inc), .clr(cnt_clr), .cnt_o(cur_cnt)
    );

    logic signed [63:0] sval;
    logic out_range, is_mem, id_bad, no_room, known;
    err_e err_now;

    always_comb begin
        sval      = $signed(msg_val);
        out_range = (sval < -64'sd1) || (sval > 64'sd65535);
        is_mem    = (sval == -64'sd1);
        id_bad    = msg_hnd || (sval < 64'sd0) || (sval > 64'(ID_LIMIT));
        no_room   = ({1'b0, peer} >= 17'(MAX_PEERS));
        known     = ({1'b0, peer} < q.cap);

        d        = q;
        d.conn   = 1'b0;
        d.disc   = 1'b0;
        d.mem    = 1'b0;
        cnt_inc  = 1'b0;
        cnt_clr  = 1'b0;
        err_now  = E_NONE;

        if (msg_vld) begin
            unique case (q.phase)
                PH_VER: begin
                    if (msg_val == PROTO_VERSION && !msg_hnd) d.phase = PH_ID;
                    else                                      err_now = E_VERSION;
                end
                PH_ID: begin
                    if (id_bad) begin
                        err_now = E_ID;
                    end else begin
                        d.own = peer;
                        if (cfg_master && peer != 16'd0) err_now = E_MASTER;
                        else                             d.phase = PH_SETUP;
                    end
                end
                PH_SETUP, PH_RUN: begin
                    if (out_range) begin
                        err_now = E_RANGE;
                    end else if (is_mem) begin
                        if (q.phase == PH_SETUP) begin
                            d.mem   = 1'b1;
                            d.phase = PH_RUN;
                        end else begin
                            err_now = E_DUP_MEM;
                        end
                    end else if (no_room) begin
                        err_now = E_NO_ROOM;
                    end else begin
                        if (!known) d.cap = {1'b0, peer} + 17'd1;
                        if (msg_hnd) begin
                            if (cur_cnt >= CW'(NUM_VECTORS)) begin
                                err_now = E_VEC_FULL;
                            end else begin
                                d.conn      = 1'b1;
                                d.conn_peer = peer;
                                d.conn_vec  = cur_cnt;
                                cnt_inc     = 1'b1;
                            end
                        end else if (peer == q.own || !known) begin
                            err_now = E_DISC;
                        end else begin
                            d.disc      = 1'b1;
                            d.disc_peer = peer;
                            cnt_clr     = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (err_now != E_NONE) begin
            if (!q.err) begin
                d.err  = 1'b1;
                d.code = err_now;
            end
            if (q.phase != PH_RUN) d.phase = PH_HALT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_VER;
            q.cap   <= 17'(INIT_CAP);
            q.code  <= E_NONE;
        end else begin
            q <= d;
        end
    end

    assign conn_stb  = q.conn;
    assign conn_peer = q.conn_peer;
    assign conn_vec  = q.conn_vec;
    assign disc_stb  = q.disc;
    assign disc_peer = q.disc_peer;
    assign mem_ready = q.mem;
    assign err_flag  = q.err;
    assign err_code  = q.code;

    // R6: event strobes never overlap
    a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({conn_stb, disc_stb, mem_ready}));
    // R6: memory-ready only marks the step from setup into run
    a_r6_mem_from_setup: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> (q.phase == PH_RUN && $past(q.phase) == PH_SETUP));
    // R7: handed-out vectors stay inside the configured range
    a_r7_vec_bound: assert property (@(posedge clk) disable iff (!rst_n)
        conn_stb |-> (conn_vec < CW'(NUM_VECTORS)));
    // R10: own ID is never reported as disconnected
    a_r10_no_own_disc: assert property (@(posedge clk) disable iff (!rst_n)
        disc_stb |-> (disc_peer != q.own));
    // R11: capacity only grows
    a_r11_cap_grows: assert property (@(posedge clk) disable iff (!rst_n)
        q.cap >= $past(q.cap));
    // R13: error flag and first code are sticky
    a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_flag) |-> (err_flag && $stable(err_code)));
    // R13: a halted block stays silent
    a_r13_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_HALT) |=> !(conn_stb || disc_stb || mem_ready));
endmodule

// File: tb/test_setup_msg_sequencer.sv
module test_setup_msg_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_handle = 1'b0;
    logic        conn_stb, disc_stb, mem_ready, err_flag;
    logic [15:0] conn_peer, disc_peer;
    logic [2:0]  conn_vec;
    logic [3:0]  err_code;

    always #5 clk = ~clk;

    setup_msg_sequencer i_setup_msg_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_handle(rx_handle),
        .conn_stb(conn_stb), .conn_peer(conn_peer), .conn_vec(conn_vec),
        .disc_stb(disc_stb), .disc_peer(disc_peer), .mem_ready(mem_ready),
        .err_flag(err_flag), .err_code(err_code)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit armed  = 0;

    // Reference model: 0 version, 1 id, 2 setup, 3 run, 4 halted
    int     m_phase = 0, m_cap = 16, m_own = 0, m_nb = 0;
    int     m_cnt [32];
    longint m_acc = 0;
    bit     m_conn = 0, m_disc = 0, m_mem = 0, m_errf = 0;
    int     m_code = 0, m_cp = 0, m_cv = 0, m_dp = 0;
    string  exp_req = "R1";

    task automatic m_error(input int c, input string r);
        if (!m_errf) begin m_errf = 1; m_code = c; end
        if (m_phase != 3) m_phase = 4;
        exp_req = r;
    endtask

    task automatic m_message(input longint v, input bit h);
        int p;
        bit kn;
        case (m_phase)
            0: begin
                exp_req = "R2";
                if (v == 0 && !h) m_phase = 1; else m_error(1, "R2");
            end
            1: begin
                exp_req = "R3";
                if (h || v < 0 || v > 65535) m_error(2, "R3");
                else begin
                    m_own = int'(v);
                    if (cfg_master && v != 0) m_error(7, "R4");
                    else begin m_phase = 2; if (cfg_master) exp_req = "R4"; end
                end
            end
            2, 3: begin
                if (v < -1 || v > 65535) m_error(3, "R5");
                else if (v == -1) begin
                    if (m_phase == 2) begin m_mem = 1; m_phase = 3; exp_req = "R6"; end
                    else m_error(4, "R6");
                end else if (v >= 32) m_error(8, "R12");
                else begin
                    p  = int'(v);
                    kn = p < m_cap;
                    exp_req = "R7";
                    if (!kn) begin m_cap = p + 1; exp_req = "R11"; end
                    if (h) begin
                        if (m_cnt[p] >= 4) m_error(5, "R8");
                        else begin m_conn = 1; m_cp = p; m_cv = m_cnt[p]; m_cnt[p]++; end
                    end else if (p == m_own || !kn) m_error(6, "R10");
                    else begin m_disc = 1; m_dp = p; m_cnt[p] = 0; exp_req = "R9"; end
                end
            end
            default: exp_req = "R13";
        endcase
    endtask

    always @(posedge clk) begin
        m_conn = 0; m_disc = 0; m_mem = 0;
        if (!rst_n) begin
            m_phase = 0; m_cap = 16; m_own = 0; m_nb = 0; m_acc = 0;
            m_errf = 0; m_code = 0; exp_req = "R1";
            for (int i = 0; i < 32; i++) m_cnt[i] = 0;
            armed = 1;
        end else if (rx_valid) begin
            m_acc = m_acc | (longint'(rx_byte) << (8 * m_nb));
            m_nb++;
            exp_req = "R1";
            if (m_nb == 8) begin
                m_message(m_acc, rx_handle);
                m_acc = 0;
                m_nb  = 0;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(negedge clk) begin
        if (armed) begin
            checks++;
            if (conn_stb !== m_conn || disc_stb !== m_disc || mem_ready !== m_mem ||
                err_flag !== m_errf || err_code !== 4'(m_code) ||
                (m_conn && (conn_peer !== 16'(m_cp) || conn_vec !== 3'(m_cv))) ||
                (m_disc && disc_peer !== 16'(m_dp))) begin
                fails++;
                $display("FAIL %s t=%0t: actual conn=%0b/%0d/%0d disc=%0b/%0d mem=%0b err=%0b/%0d expected conn=%0b/%0d/%0d disc=%0b/%0d mem=%0b err=%0b/%0d",
                    exp_req, $time, conn_stb, conn_peer, conn_vec, disc_stb, disc_peer,
                    mem_ready, err_flag, err_code, m_conn, m_cp, m_cv, m_disc, m_dp,
                    m_mem, m_errf, m_code);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic do_reset(input bit master);
        @(negedge clk); #1;
        rst_n = 0; rx_valid = 0; rx_handle = 0; cfg_master = master;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
    endtask

    task automatic send_msg(input longint v, input bit h, input int gap);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            rx_valid = 1; rx_byte = v[8*i +: 8]; rx_handle = h;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); #1;
                rx_valid = 0;
            end
        end
        @(negedge clk); #1;
        rx_valid = 0; rx_handle = 0;
    endtask

    initial begin
        // R1 reset state, then a full setup and run sequence
        do_reset(0);
        send_msg(0, 0, 0);
        send_msg(2, 0, 1);
        send_msg(0, 1, 0);             // R7 connect peer 0 vector 0
        send_msg(2, 1, 0);             // R7 own connect
        send_msg(2, 1, 3);             // R7 vector 1, R1 gaps
        send_msg(-1, 0, 0);            // R6 memory ready
        for (int k = 0; k < 4; k++) send_msg(5, 1, 2);
        send_msg(5, 1, 0);             // R8 full
        send_msg(5, 0, 0);             // R9 disconnect
        send_msg(5, 1, 0);             // R9 vector restarts at 0
        send_msg(2, 0, 0);             // R10 own id
        send_msg(20, 0, 0);            // R10 unknown peer
        send_msg(25, 1, 0);            // R11 growth
        send_msg(20, 0, 0);            // R11 now known
        send_msg(40, 1, 0);            // R12 no storage
        send_msg(-5, 0, 0);            // R5
        send_msg(70000, 1, 0);         // R5
        send_msg(-1, 0, 0);            // R6 duplicate
        send_msg(3, 1, 0);             // R13 run continues

        // R2 wrong version halts, later traffic ignored (R13)
        do_reset(0);
        send_msg(7, 0, 0);
        send_msg(0, 0, 0);
        send_msg(0, 0, 0);
        send_msg(1, 1, 0);
        // R2 version with a handle
        do_reset(0);
        send_msg(0, 1, 0);
        // R3 bad ids
        do_reset(0);
        send_msg(0, 0, 0); send_msg(4, 1, 0);
        do_reset(0);
        send_msg(0, 0, 0); send_msg(70000, 0, 0);
        do_reset(0);
        send_msg(0, 0, 0); send_msg(-3, 0, 0); send_msg(-1, 0, 0);
        // R4 master rules
        do_reset(1);
        send_msg(0, 0, 0); send_msg(3, 0, 0); send_msg(-1, 0, 0);
        do_reset(1);
        send_msg(0, 0, 0); send_msg(0, 0, 0); send_msg(3, 1, 1); send_msg(-1, 0, 0);
        // R13 setup errors halt
        do_reset(0);
        send_msg(0, 0, 0); send_msg(1, 0, 0); send_msg(100, 1, 0); send_msg(-1, 0, 0);
        do_reset(0);
        send_msg(0, 0, 0); send_msg(1, 0, 0); send_msg(-2, 0, 0); send_msg(-1, 0, 0);
        do_reset(0);
        send_msg(0, 0, 0); send_msg(1, 0, 0); send_msg(17, 0, 0); send_msg(-1, 0, 0);
        // R11 growth during setup, then disconnect valid in run
        do_reset(0);
        send_msg(0, 0, 4); send_msg(1, 0, 0); send_msg(30, 1, 0);
        send_msg(-1, 0, 0); send_msg(30, 0, 0); send_msg(30, 1, 0);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule